// File: doc/BRIEF.md
# Leaky integrate-and-fire neuron

This block is one digital spiking neuron that works in discrete time steps. A controller opens a step with a start strobe and closes it with an end strobe. In between, a stream of signed weighted inputs arrives, each marked by a valid flag, and each accepted input is added into the membrane potential register. Additions clamp at the signed range limits instead of wrapping.

At the end strobe the neuron subtracts a constant leak and compares the result against its threshold. The leak is skipped in integrate-only mode, and a leak of zero gives the same result. If the result reaches the threshold, the neuron emits a one-cycle spike, sets the membrane back to a configurable resting value, and becomes refractory for a configurable number of steps. While refractory it ignores inputs and does not fire.

An optional adaptive threshold adds an offset to the base threshold. The offset grows by a set amount on every spike and shrinks by one on every other end strobe. This lets a neuron that fires often raise its own threshold.

Top module: `lif_neuron`

## Requirements
- R1: After reset, spike is 0, the membrane output vmem is 0, no refractory period is active and the adaptive threshold offset is 0.
- R2: A weighted input is accepted only when in_valid is high in a cycle after the step_start cycle and before the step_end cycle of the same step. Inputs in the step_start cycle, in the step_end cycle and outside a step leave vmem unchanged.
- R3: Each accepted input adds in_weight (two's complement) to vmem. The sum clamps to the most positive or most negative value of the vmem width and never wraps.
- R4: At step_end the neuron computes vmem minus leak, clamped to the signed range. It fires when this value is greater than or equal to the effective threshold. Otherwise vmem takes this value.
- R5: A firing produces spike = 1 for exactly one cycle, in the cycle right after the step_end cycle.
- R6: After a firing, vmem equals the rest_val that was present in the step_end cycle.
- R7: A firing loads the refractory counter with refrac_len. While the counter is nonzero, inputs are ignored, vmem is held and the neuron cannot fire. The counter drops by one at each step_end, so the neuron stays silent for exactly refrac_len whole steps.
- R8: When integrate_only is 1, the leak is not applied at step_end.
- R9: With adapt_en = 1, the effective threshold is base_thresh plus an offset. The offset rises by adapt_inc (clamped) at each firing step_end and falls by one, down to zero, at every other step_end. With adapt_en = 0, the offset is held at zero and the threshold is base_thresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_start | input | 1 | Opens a time step |
| step_end | input | 1 | Closes a time step; triggers leak, compare and fire |
| in_valid | input | 1 | Qualifies in_weight |
| in_weight | input | WW (8) | Signed weighted input |
| leak | input | VW (16) | Signed leak constant subtracted at step end |
| base_thresh | input | VW (16) | Signed base firing threshold |
| rest_val | input | VW (16) | Signed membrane value loaded after a spike |
| refrac_len | input | RW (4) | Number of silent steps after a spike |
| integrate_only | input | 1 | 1 disables the leak |
| adapt_en | input | 1 | Enables the adaptive threshold offset |
| adapt_inc | input | VW-1 (15) | Offset added on each spike |
| spike | output | 1 | One-cycle spike pulse |
| vmem | output | VW (16) | Signed membrane potential |

## Verification
Two behaviours are hard to reach from the ports.

The first is the clamp. It needs hundreds of same-sign inputs in one step, so the bench feeds 300 inputs of +127 and later 300 of −128. It then reads vmem before the end strobe, at both limits.

The second is the decaying adaptive offset. It can only be seen as a change in when the neuron fires. The bench fires once to build an offset of 50, then supplies sums of 100, 148 and 148 over later steps. These values place the membrane exactly one below and then exactly at the threshold as the offset decays, which shows a decay of one per step.

// File: rtl/lif_pkg.sv
package lif_pkg;

  // Clamp a wide signed value to the signed range of w bits (w < 31).
  function automatic logic signed [31:0] clamp_signed(input logic signed [31:0] x,
                                                      input int w);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    hi = (32'sd1 <<< (w - 1)) - 32'sd1;
    lo = -(32'sd1 <<< (w - 1));
    if (x > hi)      return hi;
    else if (x < lo) return lo;
    else             return x;
  endfunction

  // Unsigned add clamped to the maximum of w bits.
  function automatic logic [31:0] clamp_uadd(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input int w);
    logic [31:0] mx;
    logic [31:0] s;
    mx = (32'd1 << w) - 32'd1;
    s  = a + b;
    return (s > mx) ? mx : s;
  endfunction

endpackage

// File: rtl/lif_step_ctrl.sv
module lif_step_ctrl #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_start,
  input  logic          step_end,
  input  logic          in_valid,
  input  logic          fire,
  input  logic [RW-1:0] refrac_len,
  output logic          acc_en,
  output logic          end_en,
  output logic          refr_active
);
  logic          in_step_q;
  logic [RW-1:0] refr_cnt_q;

  assign refr_active = (refr_cnt_q != '0);
  assign acc_en      = in_valid & in_step_q & ~step_end & ~refr_active;
  assign end_en      = step_end & ~refr_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_step_q <= 1'b0;
    end else if (step_start) begin
      in_step_q <= 1'b1;
    end else if (step_end) begin
      in_step_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refr_cnt_q <= '0;
    end else if (step_end) begin
      if (fire)             refr_cnt_q <= refrac_len;
      else if (refr_active) refr_cnt_q <= refr_cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lif_membrane.sv
module lif_membrane
  import lif_pkg::*;
#(
  parameter int VW = 16,
  parameter int WW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 end_en,
  input  logic                 fire,
  input  logic                 integrate_only,
  input  logic [WW-1:0]        in_weight,
  input  logic [VW-1:0]        leak,
  input  logic [VW-1:0]        rest_val,
  output logic [VW-1:0]        vmem,
  output logic signed [31:0]   v_leaked
);
  localparam int VPAD = 32 - VW;
  localparam int WPAD = 32 - WW;

  logic [VW-1:0]        v_q;
  logic signed [31:0]   v_ext;
  logic signed [31:0]   w_ext;
  logic signed [31:0]   l_ext;
  logic signed [31:0]   v_sum;

  assign v_ext    = {{VPAD{v_q[VW-1]}}, v_q};
  assign w_ext    = {{WPAD{in_weight[WW-1]}}, in_weight};
  assign l_ext    = integrate_only ? 32'sd0 : {{VPAD{leak[VW-1]}}, leak};
  assign v_sum    = clamp_signed(v_ext + w_ext, VW);
  assign v_leaked = clamp_signed(v_ext - l_ext, VW);
  assign vmem     = v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (end_en) begin
      v_q <= fire ? rest_val : v_leaked[VW-1:0];
    end else if (acc_en) begin
      v_q <= v_sum[VW-1:0];
    end
  end
endmodule

// File: rtl/lif_adapt_thr.sv
module lif_adapt_thr
  import lif_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_end,
  input  logic                 end_en,
  input  logic                 adapt_en,
  input  logic [VW-2:0]        adapt_inc,
  input  logic [VW-1:0]        base_thresh,
  input  logic signed [31:0]   v_leaked,
  output logic                 fire
);
  localparam int OW   = VW - 1;
  localparam int VPAD = 32 - VW;
  localparam int OPAD = 32 - OW;

  logic [OW-1:0]        off_q;
  logic signed [31:0]   eff_thr;
  logic [31:0]          off_inc;

  assign eff_thr = {{VPAD{base_thresh[VW-1]}}, base_thresh}
                 + (adapt_en ? $signed({{OPAD{1'b0}}, off_q}) : 32'sd0);
  assign fire    = end_en && (v_leaked >= eff_thr);
  assign off_inc = clamp_uadd({{OPAD{1'b0}}, off_q}, {{OPAD{1'b0}}, adapt_inc}, OW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (!adapt_en) begin
      off_q <= '0;
    end else if (step_end) begin
      if (fire)              off_q <= off_inc[OW-1:0];
      else if (off_q != '0)  off_q <= off_q - 1'b1;
    end
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron #(
  parameter int VW = 16,
  parameter int WW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_start,
  input  logic          step_end,
  input  logic          in_valid,
  input  logic [WW-1:0] in_weight,
  input  logic [VW-1:0] leak,
  input  logic [VW-1:0] base_thresh,
  input  logic [VW-1:0] rest_val,
  input  logic [RW-1:0] refrac_len,
  input  logic          integrate_only,
  input  logic          adapt_en,
  input  logic [VW-2:0] adapt_inc,
  output logic          spike,
  output logic [VW-1:0] vmem
);
  logic                acc_en;
  logic                end_en;
  logic                refr_active;
  logic                fire;
  logic signed [31:0]  v_leaked;
  logic                spike_q;

  lif_step_ctrl #(.RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .step_end(step_end),
    .in_valid(in_valid), .fire(fire), .refrac_len(refrac_len),
    .acc_en(acc_en), .end_en(end_en), .refr_active(refr_active)
  );

  lif_membrane #(.VW(VW), .WW(WW)) u_mem (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .end_en(end_en), .fire(fire),
    .integrate_only(integrate_only), .in_weight(in_weight), .leak(leak),
    .rest_val(rest_val), .vmem(vmem), .v_leaked(v_leaked)
  );

  lif_adapt_thr #(.VW(VW)) u_thr (
    .clk(clk), .rst_n(rst_n), .step_end(step_end), .end_en(end_en),
    .adapt_en(adapt_en), .adapt_inc(adapt_inc), .base_thresh(base_thresh),
    .v_leaked(v_leaked), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spike_q <= 1'b0;
    else        spike_q <= fire;
  end

  assign spike = spike_q;
endmodule

// File: rtl/lif_neuron_chk.sv
module lif_neuron_chk #(
  parameter int VW = 16,
  parameter int WW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_end,
  input logic          spike,
  input logic [VW-1:0] vmem,
  input logic [VW-1:0] rest_val,
  input logic [WW-1:0] in_weight,
  input logic          acc_en,
  input logic          refr_active
);
  // R5: a spike only follows an end strobe
  p_spike_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> $past(step_end));

  // R5: pulse lasts one cycle unless another end strobe intervenes
  p_spike_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spike && !step_end) |=> !spike);

  // R6: membrane holds the resting value after firing
  p_rest_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> (vmem == $past(rest_val)));

  // R7: membrane frozen while refractory
  p_refrac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refr_active |=> $stable(vmem));

  // R7: no spike can come from a refractory step
  p_no_fire_refrac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> !$past(refr_active));

  // R3: a non-negative input never lowers the membrane (no wrap)
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !in_weight[WW-1]) |=> ($signed(vmem) >= $past($signed(vmem))));
endmodule

bind lif_neuron lif_neuron_chk #(.VW(VW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_end(step_end), .spike(spike), .vmem(vmem),
  .rest_val(rest_val), .in_weight(in_weight), .acc_en(acc_en),
  .refr_active(refr_active)
);

// File: tb/lif_neuron_bench.sv
module lif_neuron_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 16;
  localparam int WW = 8;
  localparam int RW = 4;
  localparam int NV = 11;
  // columns: inputs, weight, integrate_only, expected spike, expected vmem
  localparam int TBL [0:NV-1][0:4] = '{
    '{3, 20, 0, 0, 55},
    '{2, 20, 0, 0, 90},
    '{1, 15, 0, 1, 0},
    '{4, 30, 0, 0, 0},
    '{4, 30, 0, 0, 0},
    '{4, 30, 0, 1, 0},
    '{0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0},
    '{3, -10, 0, 0, -35},
    '{0, 0, 0, 0, -40},
    '{0, 0, 1, 0, -40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_start = 1'b0, step_end = 1'b0, in_valid = 1'b0;
  logic [WW-1:0] in_weight = '0;
  logic [VW-1:0] leak = 16'sd5, base_thresh = 16'sd100, rest_val = '0;
  logic [RW-1:0] refrac_len = 4'd2;
  logic integrate_only = 1'b0, adapt_en = 1'b0;
  logic [VW-2:0] adapt_inc = '0;
  logic spike;
  logic [VW-1:0] vmem;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lif_neuron #(.VW(VW), .WW(WW), .RW(RW)) u_lif_neuron (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .step_end(step_end),
    .in_valid(in_valid), .in_weight(in_weight), .leak(leak),
    .base_thresh(base_thresh), .rest_val(rest_val), .refrac_len(refrac_len),
    .integrate_only(integrate_only), .adapt_en(adapt_en),
    .adapt_inc(adapt_inc), .spike(spike), .vmem(vmem)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int vm();
    return int'($signed(vmem));
  endfunction

  task automatic open_step();
    @(negedge clk); step_start = 1'b1;
    @(negedge clk); step_start = 1'b0;
  endtask

  task automatic feed(input int n, input int w);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1; in_weight = w[WW-1:0];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic close_step();
    step_end = 1'b1;
    @(negedge clk); step_end = 1'b0;
  endtask

  task automatic run_step(input int n, input int w);
    open_step(); feed(n, w); close_step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 spike", int'(spike), 0);
    chk("R1 vmem", vm(), 0);

    // vector table: leak 5, threshold 100, refractory 2 steps
    for (int i = 0; i < NV; i++) begin
      integrate_only = TBL[i][2][0];
      run_step(TBL[i][0], TBL[i][1]);
      chk($sformatf("R4/R7/R8 step%0d spike", i), int'(spike), TBL[i][3]);
      chk($sformatf("R4/R6/R7/R8 step%0d vmem", i), vm(), TBL[i][4]);
      @(negedge clk);
      chk($sformatf("R5 step%0d pulse end", i), int'(spike), 0);
    end
    integrate_only = 1'b0;

    // R2: inputs outside a step and in the start cycle are ignored
    leak = '0;
    feed(3, 50);
    chk("R2 outside step", vm(), -40);
    @(negedge clk); step_start = 1'b1; in_valid = 1'b1; in_weight = 8'd50;
    @(negedge clk); step_start = 1'b0; in_valid = 1'b0;
    chk("R2 start cycle", vm(), -40);
    in_valid = 1'b1; step_end = 1'b1;
    @(negedge clk); step_end = 1'b0; in_valid = 1'b0;
    chk("R2 end cycle", vm(), -40);

    // R3: positive clamp, then fire at exact max threshold
    refrac_len = '0; base_thresh = 16'h7FFF;
    open_step(); feed(300, 127);
    chk("R3 positive clamp", vm(), 32767);
    close_step();
    chk("R4 fire at max", int'(spike), 1);
    chk("R6 rest after fire", vm(), 0);

    // R3: negative clamp, leak at the limit keeps the clamp
    base_thresh = 16'sd100; leak = 16'sd5;
    open_step(); feed(300, -128);
    chk("R3 negative clamp", vm(), -32768);
    close_step();
    chk("R3 leak clamp", vm(), -32768);
    chk("R4 no fire negative", int'(spike), 0);

    // R1 again after mid-run reset; R6 with non-zero rest
    do_reset();
    chk("R1 vmem after reset", vm(), 0);
    leak = '0; rest_val = -16'sd20;
    run_step(4, 25);
    chk("R4 fire equal", int'(spike), 1);
    chk("R6 negative rest", vm(), -20);

    // R9: adaptive threshold
    rest_val = '0; adapt_en = 1'b1; adapt_inc = 15'd50;
    run_step(4, 30);
    chk("R9 first fire", int'(spike), 1);
    run_step(4, 25);
    chk("R9 raised threshold blocks", int'(spike), 0);
    chk("R9 vmem kept", vm(), 100);
    run_step(1, 48);
    chk("R9 one below decayed thr", int'(spike), 0);
    run_step(0, 0);
    chk("R9 fire at decayed thr", int'(spike), 1);
    adapt_en = 1'b0;
    run_step(4, 25);
    chk("R9 disabled offset", int'(spike), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule